// File: doc/BRIEF.md
# Retention-Ranked Way Placement for One Cache Set

This block manages the four ways of one set in a set-associative cache built from dynamic cells whose data retention time differs from way to way. A ranking of the physical ways, fixed at test time, lists them from the longest retention to the shortest. A second test-time input marks ways that cannot hold data at all. The ways that are not marked dead form a ranked list of usable slots.

When a line is filled, the block inserts it at the top of the list and pushes every resident line one slot down. The line in the lowest usable slot falls out of the set. A line that is dirty when it falls out is offered on a write-back stream before anything overwrites it. Every push copies a whole line through a per-destination way multiplexer, one 64-bit beat per cycle. Rewriting a line in a new way also restores its charge, so each push doubles as a refresh. Lookups never reorder anything.

Both data paths are valid/ready streams. The fill producer must hold `fill_valid`, `fill_tag`, `fill_dirty` and `fill_line` steady until it sees `fill_ready`. The block asserts `fill_ready` only in the cycle in which the last beat of the new line is written. While `wb_valid` is high and `wb_ready` is low, `wb_tag` and `wb_line` do not change. The block does nothing else until the write-back is taken.

Top module: `ret_rank_placer`

## Requirements
- R1: `rank_cfg` bits [2r+1:2r] name the physical way at rank r, and rank 0 is the longest retention. `dead_mask` bit w marks way w as dead, and a dead way never holds a valid line. Both inputs change only while `rst_n` is low.
- R2: A fill moves each resident line one usable slot down, in rank order. The line's tag, valid bit and dirty bit move with its data.
- R3: A fill into a set whose usable slots are all occupied drops the line in the lowest usable slot. If that line is dirty, it appears on `wb_tag`/`wb_line` before it is overwritten. A clean line produces no write-back.
- R4: `wb_tag` and `wb_line` stay stable while `wb_valid` is high and `wb_ready` is low, and `wb_valid` stays high until the handshake.
- R5: A new line always lands in the top usable slot. Measured in rising edges from the first edge that sees `fill_valid` up to and including the handshake edge, a fill takes 1 + (cycles `wb_valid` is high) + 8 × (lines moved) + 8.
- R6: `busy` is low while idle. It is high from the edge that accepts a fill request until the handshake, and low again after the handshake.
- R7: `hit` rises and `hit_way` gives the physical way when a valid line's tag equals `lookup_tag`. Lookups and `peek_way` never change the contents of the set.
- R8: When every way is dead, `set_unusable` is 1 and `hit` is 0. In that state, a fill is accepted in the cycle it is presented and stores nothing.
- R9: After reset, all ways are invalid, `busy` is 0 and `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rank_cfg | input | 8 | Physical way per rank, rank 0 longest retention |
| dead_mask | input | 4 | One bit per physical way, 1 = dead |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted (new line fully written) |
| fill_tag | input | 20 | Tag of the incoming line |
| fill_dirty | input | 1 | Dirty state of the incoming line |
| fill_line | input | 512 | Incoming line data |
| wb_valid | output | 1 | Dirty victim offered |
| wb_ready | input | 1 | Victim taken |
| wb_tag | output | 20 | Victim tag |
| wb_line | output | 512 | Victim data |
| busy | output | 1 | Placement sequence in progress |
| lookup_tag | input | 20 | Tag to search |
| hit | output | 1 | A valid way holds `lookup_tag` |
| hit_way | output | 2 | Physical way of the hit |
| set_unusable | output | 1 | All ways dead |
| peek_way | input | 2 | Physical way to observe |
| peek_valid | output | 1 | Valid bit of the observed way |
| peek_tag | output | 20 | Tag of the observed way |
| peek_dirty | output | 1 | Dirty bit of the observed way |
| peek_line | output | 512 | Data of the observed way |

## Verification
Fills are tried on an identity ranking with no dead way, on a reversed ranking with one dead way, on a set with a single usable way, on a set where every way is dead, and on random permutations with random dead masks. The identity case shows that lines shift in rank order. The reversed and random cases show that physical way numbers and rank slots are kept apart and that dead ways are skipped. The single-way case exercises an eviction with no move at all. Random dirty bits and random write-back back-pressure separate clean drops from held, stable write-backs. Every fill's latency is matched against the move count, which exposes a copy that is too short or too long.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_MOVE  = 2'd2,
    ST_WRITE = 2'd3
  } rrp_state_e;
endpackage

// File: rtl/rrp_rank_list.sv
// Compacts the test-time ranking into a list of usable slots.
module rrp_rank_list #(
  parameter int NWAYS = 4,
  localparam int IDX_W = $clog2(NWAYS),
  localparam int CNT_W = $clog2(NWAYS + 1)
) (
  input  logic [NWAYS*IDX_W-1:0] rank_cfg,
  input  logic [NWAYS-1:0]       dead_mask,
  output logic [NWAYS*IDX_W-1:0] slot_way,
  output logic [CNT_W-1:0]       usable_cnt
);
  always_comb begin
    int k;
    logic [IDX_W-1:0] w;
    k = 0;
    slot_way = '0;
    for (int r = 0; r < NWAYS; r++) begin
      w = rank_cfg[r*IDX_W +: IDX_W];
      if (!dead_mask[w]) begin
        slot_way[k*IDX_W +: IDX_W] = w;
        k = k + 1;
      end
    end
    usable_cnt = CNT_W'(k);
  end
endmodule

// File: rtl/rrp_way_array.sv
// Line storage: one register line per way, each fed by its own way-select mux.
module rrp_way_array #(
  parameter int NWAYS  = 4,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 8,
  localparam int IDX_W  = $clog2(NWAYS),
  localparam int BIDX_W = $clog2(BEATS),
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWAYS-1:0]        wr_en,
  input  logic                    wr_src_fill,
  input  logic [IDX_W-1:0]        wr_src_way,
  input  logic [BIDX_W-1:0]       wr_beat,
  input  logic [LINE_W-1:0]       fill_line,
  output logic [NWAYS*LINE_W-1:0] all_lines
);
  logic [BEAT_W-1:0] fill_beat;
  assign fill_beat = fill_line[wr_beat*BEAT_W +: BEAT_W];

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] src_line;
    logic [BEAT_W-1:0] src_beat;
    // per-destination way multiplexer
    assign src_line = all_lines[wr_src_way*LINE_W +: LINE_W];
    assign src_beat = wr_src_fill ? fill_beat : src_line[wr_beat*BEAT_W +: BEAT_W];
    always_ff @(posedge clk) begin
      if (wr_en[g]) line_q[wr_beat*BEAT_W +: BEAT_W] <= src_beat;
    end
    assign all_lines[g*LINE_W +: LINE_W] = line_q;
  end

  // R2
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/rrp_ctrl.sv
// Sequencer: eviction, bottom-up copies, then the new line at the top.
module rrp_ctrl
  import rrp_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int TAG_W = 20,
  parameter int BEATS = 8,
  localparam int IDX_W  = $clog2(NWAYS),
  localparam int CNT_W  = $clog2(NWAYS + 1),
  localparam int BIDX_W = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWAYS*IDX_W-1:0]  slot_way,
  input  logic [CNT_W-1:0]        usable_cnt,
  input  logic                    fill_valid,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic                    fill_dirty,
  output logic                    fill_ready,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [IDX_W-1:0]        wb_way,
  output logic                    busy,
  output logic [NWAYS-1:0]        meta_valid,
  output logic [NWAYS-1:0]        meta_dirty,
  output logic [NWAYS*TAG_W-1:0]  meta_tag,
  output logic [NWAYS-1:0]        wr_en,
  output logic                    wr_src_fill,
  output logic [IDX_W-1:0]        wr_src_way,
  output logic [BIDX_W-1:0]       wr_beat
);
  localparam logic [BIDX_W-1:0] LAST_BEAT = BIDX_W'(BEATS - 1);

  rrp_state_e        state_q;
  logic [IDX_W-1:0]  cur_q;
  logic [BIDX_W-1:0] beat_q;
  logic [NWAYS-1:0]  v_q, d_q;
  logic [NWAYS*TAG_W-1:0] t_q;

  logic [IDX_W-1:0] sw [NWAYS];
  always_comb begin
    for (int s = 0; s < NWAYS; s++) sw[s] = slot_way[s*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0] bot_slot, src_way, dst_way, top_way;
  logic             full, evict_dirty;
  int               occ, first_mv;
  rrp_state_e       start_state;
  logic [IDX_W-1:0] start_cur;

  always_comb begin
    occ = 0;
    for (int s = 0; s < NWAYS; s++) begin
      if (s < int'(usable_cnt) && v_q[sw[s]]) occ = occ + 1;
    end
    full        = (usable_cnt != '0) && (occ == int'(usable_cnt));
    bot_slot    = (usable_cnt == '0) ? '0 : IDX_W'(usable_cnt - 1'b1);
    wb_way      = sw[bot_slot];
    evict_dirty = full && d_q[wb_way];
    first_mv    = full ? int'(usable_cnt) - 2 : occ - 1;
    start_state = (first_mv >= 0) ? ST_MOVE : ST_WRITE;
    start_cur   = (first_mv >= 0) ? IDX_W'(first_mv) : '0;
    src_way     = sw[cur_q];
    dst_way     = sw[cur_q + 1'b1];
    top_way     = sw[0];
  end

  always_comb begin
    wr_en       = '0;
    wr_src_fill = 1'b0;
    wr_src_way  = src_way;
    wr_beat     = beat_q;
    fill_ready  = 1'b0;
    wb_valid    = 1'b0;
    unique case (state_q)
      ST_IDLE:  fill_ready = (usable_cnt == '0);
      ST_EVICT: wb_valid = 1'b1;
      ST_MOVE:  wr_en[dst_way] = 1'b1;
      ST_WRITE: begin
        wr_en[top_way] = 1'b1;
        wr_src_fill    = 1'b1;
        fill_ready     = (beat_q == LAST_BEAT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      beat_q  <= '0;
      v_q     <= '0;
      d_q     <= '0;
      t_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fill_valid && usable_cnt != '0) begin
          beat_q <= '0;
          if (evict_dirty) state_q <= ST_EVICT;
          else begin
            state_q <= start_state;
            cur_q   <= start_cur;
          end
        end
        ST_EVICT: if (wb_ready) begin
          state_q <= start_state;
          cur_q   <= start_cur;
          beat_q  <= '0;
        end
        ST_MOVE: begin
          if (beat_q == LAST_BEAT) begin
            v_q[dst_way] <= v_q[src_way];
            d_q[dst_way] <= d_q[src_way];
            t_q[dst_way*TAG_W +: TAG_W] <= t_q[src_way*TAG_W +: TAG_W];
            beat_q <= '0;
            if (cur_q == '0) state_q <= ST_WRITE;
            else cur_q <= cur_q - 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (beat_q == LAST_BEAT) begin
            v_q[top_way] <= 1'b1;
            d_q[top_way] <= fill_dirty;
            t_q[top_way*TAG_W +: TAG_W] <= fill_tag;
            beat_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign meta_valid = v_q;
  assign meta_dirty = d_q;
  assign meta_tag   = t_q;

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> !busy);
  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready && (usable_cnt != '0) |-> busy);
endmodule

// File: rtl/ret_rank_placer.sv
module ret_rank_placer #(
  parameter int NWAYS  = 4,
  parameter int TAG_W  = 20,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 8,
  localparam int IDX_W  = $clog2(NWAYS),
  localparam int CNT_W  = $clog2(NWAYS + 1),
  localparam int BIDX_W = $clog2(BEATS),
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWAYS*IDX_W-1:0] rank_cfg,
  input  logic [NWAYS-1:0]       dead_mask,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic                   fill_dirty,
  input  logic [LINE_W-1:0]      fill_line,
  output logic                   wb_valid,
  input  logic                   wb_ready,
  output logic [TAG_W-1:0]       wb_tag,
  output logic [LINE_W-1:0]      wb_line,
  output logic                   busy,
  input  logic [TAG_W-1:0]       lookup_tag,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_way,
  output logic                   set_unusable,
  input  logic [IDX_W-1:0]       peek_way,
  output logic                   peek_valid,
  output logic [TAG_W-1:0]       peek_tag,
  output logic                   peek_dirty,
  output logic [LINE_W-1:0]      peek_line
);
  logic [NWAYS*IDX_W-1:0]  slot_way;
  logic [CNT_W-1:0]        usable_cnt;
  logic [NWAYS-1:0]        meta_valid, meta_dirty, wr_en;
  logic [NWAYS*TAG_W-1:0]  meta_tag;
  logic                    wr_src_fill;
  logic [IDX_W-1:0]        wr_src_way, wb_way;
  logic [BIDX_W-1:0]       wr_beat;
  logic [NWAYS*LINE_W-1:0] all_lines;

  rrp_rank_list #(.NWAYS(NWAYS)) u_list (
    .rank_cfg(rank_cfg), .dead_mask(dead_mask),
    .slot_way(slot_way), .usable_cnt(usable_cnt)
  );

  rrp_ctrl #(.NWAYS(NWAYS), .TAG_W(TAG_W), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_way(slot_way), .usable_cnt(usable_cnt),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .fill_ready(fill_ready), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_way(wb_way), .busy(busy), .meta_valid(meta_valid),
    .meta_dirty(meta_dirty), .meta_tag(meta_tag), .wr_en(wr_en),
    .wr_src_fill(wr_src_fill), .wr_src_way(wr_src_way), .wr_beat(wr_beat)
  );

  rrp_way_array #(.NWAYS(NWAYS), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_ways (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src_fill(wr_src_fill),
    .wr_src_way(wr_src_way), .wr_beat(wr_beat), .fill_line(fill_line),
    .all_lines(all_lines)
  );

  assign wb_tag       = meta_tag[wb_way*TAG_W +: TAG_W];
  assign wb_line      = all_lines[wb_way*LINE_W +: LINE_W];
  assign set_unusable = (usable_cnt == '0);

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (!hit && meta_valid[w] && meta_tag[w*TAG_W +: TAG_W] == lookup_tag) begin
        hit     = 1'b1;
        hit_way = IDX_W'(w);
      end
    end
  end

  assign peek_valid = meta_valid[peek_way];
  assign peek_dirty = meta_dirty[peek_way];
  assign peek_tag   = meta_tag[peek_way*TAG_W +: TAG_W];
  assign peek_line  = all_lines[peek_way*LINE_W +: LINE_W];

  // R4
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_tag) && $stable(wb_line));
  // R1
  dead_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_valid & dead_mask) == '0);
  // R8
  unusable_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_unusable |-> !hit);
endmodule

// File: tb/ret_rank_placer_test.sv
module ret_rank_placer_test;
  localparam int NW = 4, TW = 20, LW = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] rank_cfg = 8'hE4;
  logic [3:0] dead_mask = 4'h0;
  logic fill_valid = 1'b0, fill_ready, fill_dirty = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic [LW-1:0] fill_line = '0;
  logic wb_valid, wb_ready = 1'b0;
  logic [TW-1:0] wb_tag;
  logic [LW-1:0] wb_line;
  logic busy, hit, set_unusable, peek_valid, peek_dirty;
  logic [TW-1:0] lookup_tag = '0, peek_tag;
  logic [1:0] hit_way, peek_way = '0;
  logic [LW-1:0] peek_line;

  ret_rank_placer uut (.*);

  int checks = 0, errors = 0;
  bit mv[NW], md[NW];
  logic [TW-1:0] mt[NW];
  logic [LW-1:0] ml[NW];
  int rk[NW], ul[NW], ucnt;
  logic [3:0] dm;
  int tag_seq = 1;

  task automatic check(input bit ok, input string req,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic configure();
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < NW; r++) rank_cfg[2*r +: 2] = 2'(rk[r]);
    dead_mask = dm;
    ucnt = 0;
    for (int r = 0; r < NW; r++) if (!dm[rk[r]]) begin ul[ucnt] = rk[r]; ucnt++; end
    for (int w = 0; w < NW; w++) begin mv[w] = 0; md[w] = 0; mt[w] = '0; ml[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(busy == 1'b0, "R9 busy", LW'(busy), 0);
    check(wb_valid == 1'b0, "R9 wb_valid", LW'(wb_valid), 0);
    check(set_unusable == (ucnt == 0), "R8 set_unusable", LW'(set_unusable), LW'(ucnt == 0));
    for (int w = 0; w < NW; w++) begin
      peek_way = 2'(w); #1;
      check(peek_valid == 1'b0, "R9 empty way", LW'(peek_valid), 0);
    end
  endtask

  task automatic check_contents(input string req);
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      peek_way = 2'(w); #1;
      check(peek_valid == mv[w], req, LW'(peek_valid), LW'(mv[w]));
      if (mv[w]) begin
        check(peek_tag == mt[w], req, LW'(peek_tag), LW'(mt[w]));
        check(peek_dirty == md[w], req, LW'(peek_dirty), LW'(md[w]));
        check(peek_line == ml[w], req, peek_line, ml[w]);
      end
    end
  endtask

  task automatic check_lookups();
    for (int w = 0; w < NW; w++) if (mv[w]) begin
      @(negedge clk);
      lookup_tag = mt[w]; #1;
      check(hit && hit_way == 2'(w), "R7 hit way", LW'({hit, hit_way}), LW'({1'b1, 2'(w)}));
    end
    @(negedge clk);
    lookup_tag = '1; #1;
    check(hit == 1'b0, "R7 absent tag", LW'(hit), 0);
    check_contents("R7 contents after lookups");
  endtask

  task automatic do_fill(input bit dirty);
    logic [LW-1:0] line;
    logic [TW-1:0] tag;
    bit exp_wb;
    int moves, n, wbc, exp_lat, ev;
    bit done;
    for (int i = 0; i < 16; i++) line[32*i +: 32] = $urandom;
    tag = TW'(tag_seq);
    tag_seq++;
    exp_wb = 0; moves = 0; n = 0; ev = 0;
    if (ucnt > 0) begin
      for (int s = 0; s < ucnt; s++) if (mv[ul[s]]) n++;
      if (n == ucnt) begin
        ev = ul[ucnt-1];
        exp_wb = md[ev];
        moves = ucnt - 1;
      end else moves = n;
    end
    exp_lat = (ucnt == 0) ? 1 : 1 + moves * 8 + 8;
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = tag; fill_dirty = dirty; fill_line = line;
    n = 0; wbc = 0; done = 0;
    while (!done && n < 2000) begin
      #1;
      n++;
      if (n == 1) check(busy == 1'b0, "R6 idle before fill", LW'(busy), 0);
      else check(busy == 1'b1, "R6 busy during fill", LW'(busy), 1);
      if (wb_valid) begin
        wbc++;
        check(exp_wb, "R3 unexpected write-back", LW'(wb_valid), 0);
        check(wb_tag == mt[ev], "R3 write-back tag", LW'(wb_tag), LW'(mt[ev]));
        check(wb_line == ml[ev], "R4 write-back line", wb_line, ml[ev]);
      end
      wb_ready = 1'($urandom % 2);
      if (fill_ready) done = 1;
      else @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0; wb_ready = 1'b0; #1;
    check(done, "R5 fill handshake", LW'(done), 1);
    check(n == exp_lat + wbc, "R5 fill latency", LW'(n), LW'(exp_lat + wbc));
    check((wbc > 0) == exp_wb, "R3 write-back presence", LW'(wbc > 0), LW'(exp_wb));
    check(busy == 1'b0, "R6 busy after fill", LW'(busy), 0);
    if (ucnt > 0) begin
      for (int j = moves - 1; j >= 0; j--) begin
        mv[ul[j+1]] = mv[ul[j]]; md[ul[j+1]] = md[ul[j]];
        mt[ul[j+1]] = mt[ul[j]]; ml[ul[j+1]] = ml[ul[j]];
      end
      mv[ul[0]] = 1; md[ul[0]] = dirty; mt[ul[0]] = tag; ml[ul[0]] = line;
    end
    check_contents("R2 R1 placement after fill");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    // identity ranking, no dead way: shift order and dirty eviction
    rk = '{0, 1, 2, 3}; dm = 4'b0000;
    configure();
    for (int f = 0; f < 7; f++) do_fill(f % 2 == 0);
    check_lookups();
    // reversed ranking, one dead way skipped
    rk = '{3, 2, 1, 0}; dm = 4'b0100;
    configure();
    for (int f = 0; f < 6; f++) do_fill(1'b1);
    check_lookups();
    // single usable way: eviction with no move
    rk = '{1, 3, 0, 2}; dm = 4'b1011;
    configure();
    for (int f = 0; f < 3; f++) do_fill(f != 1);
    check_lookups();
    // every way dead: forced miss, fill dropped
    rk = '{0, 1, 2, 3}; dm = 4'b1111;
    configure();
    do_fill(1'b1);
    @(negedge clk);
    lookup_tag = TW'(tag_seq - 1); #1;
    check(hit == 1'b0, "R8 forced miss", LW'(hit), 0);
    // random rankings and dead masks
    for (int e = 0; e < 6; e++) begin
      rk = '{0, 1, 2, 3};
      for (int i = NW - 1; i > 0; i--) begin
        int j, t;
        j = int'($urandom % (i + 1));
        t = rk[i]; rk[i] = rk[j]; rk[j] = t;
      end
      dm = 4'($urandom % 16);
      if (dm == 4'hF) dm = 4'h0;
      configure();
      for (int f = 0; f < 9; f++) do_fill(1'($urandom % 2));
      check_lookups();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule